// File: doc/BRIEF.md
# Interrupt cause and mask controller

This block collects up to twenty-nine hardware interrupt sources into one 32-bit cause word, lets software enable each source through a 32-bit mask word, and drives one level-sensitive interrupt request toward the processor. Each source input is watched for a rising edge. An edge latches the source's cause bit, and the bit stays set until software clears it. The sources sit at cause positions 1 to 29. Positions 0, 30 and 31 are read-only summary bits. The block works them out from the raw cause bits.

Software reaches both words through a single-cycle register port. A select bit picks which word to access, reads are combinational, and writes take effect at the next clock edge. To acknowledge a source, software writes the cause word back with that source's bit at zero. Bits written as one are left as they are. Besides the request line, the block reports the lowest-numbered source that is both pending and enabled, as a valid flag and a 5-bit index. An interrupt handler can use that index to pick which source to serve.

Top module: `intc_cause_mask`

## Requirements
- R1: While reset is high and after it is released, both the cause word and the mask word read as zero, `cpu_irq` is low and `pend_valid` is low.
- R2: A rising edge on `src_in[k]` sets cause bit k+1, which reads back after the next clock edge. The bit stays set whatever the input does afterwards, until software clears it. A source that is held high does not set the bit again.
- R3: A write with `reg_sel`=0 (cause word) clears every source bit written as 0 at the next clock edge. Source bits written as 1 keep their value, and a write never sets a bit.
- R4: If a rising edge on a source arrives in the same cycle as a cause write that would clear that source's bit, the bit ends up set.
- R5: Cause bit 0 reads as the OR of raw cause bits 1 to 29.
- R6: Cause bit 30 reads as the OR of raw cause bits 1 to 20 and 26 to 29.
- R7: Cause bit 31 reads as the OR of raw cause bits 1 to 25.
- R8: Writes to positions 0, 30 and 31 are ignored in both words. In the mask word these positions always read as 0.
- R9: A write with `reg_sel`=1 loads the mask word at positions 1 to 29. A read with `reg_sel`=1 returns the stored mask.
- R10: `cpu_irq` is high exactly when some position 1 to 29 has both its raw cause bit and its mask bit set.
- R11: `pend_valid` equals `cpu_irq`. While it is high, `pend_idx` holds the lowest position that is both pending and enabled.
- R12: The summary bits come from the raw cause bits and ignore the mask: a masked-off source still shows in them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 29 | Source inputs. Bit k feeds cause position k+1 |
| reg_sel | input | 1 | Register select: 0 = cause word, 1 = mask word |
| reg_we | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the selected word |
| cpu_irq | output | 1 | Level interrupt request to the processor |
| pend_valid | output | 1 | An enabled source is pending |
| pend_idx | output | 5 | Lowest pending, enabled source position |

## Verification
A source's rising edge and a software acknowledge that clears the same cause bit can land in the same clock cycle. The bench sets this up by raising a source on the same falling edge that starts a cause write of all zeros. One case uses a source whose bit was clear before and another uses one whose bit was already set. The pass condition is that the raced bit reads back set while every other source bit is cleared. A second pairing is also covered: a source that is held high during an acknowledge must stay cleared.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int DW     = 32;
    localparam int SRC_LO = 1;
    localparam int SRC_HI = 29;
    localparam int NSRC   = SRC_HI - SRC_LO + 1;
    localparam int IDX_W  = $clog2(DW);

    localparam int SUM_ANY  = 0;
    localparam int SUM_MIX  = 30;
    localparam int SUM_LOW  = 31;

    typedef logic [DW-1:0] word_t;

    typedef enum logic {
        SEL_CAUSE = 1'b0,
        SEL_MASK  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pend_t;

    function automatic word_t src_field();
        word_t f;
        f = '0;
        for (int i = SRC_LO; i <= SRC_HI; i++) f[i] = 1'b1;
        return f;
    endfunction

    function automatic word_t mix_group();
        word_t f;
        f = '0;
        for (int i = 1; i <= 20; i++) f[i] = 1'b1;
        for (int i = 26; i <= 29; i++) f[i] = 1'b1;
        return f;
    endfunction

    function automatic word_t low_group();
        word_t f;
        f = '0;
        for (int i = 1; i <= 25; i++) f[i] = 1'b1;
        return f;
    endfunction

    function automatic word_t compose_cause(input word_t raw);
        word_t r;
        r = raw & src_field();
        r[SUM_ANY] = |(raw & src_field());
        r[SUM_MIX] = |(raw & mix_group());
        r[SUM_LOW] = |(raw & low_group());
        return r;
    endfunction

endpackage

// File: rtl/intc_edge_detect.sv
module intc_edge_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/intc_cause_reg.sv
module intc_cause_reg
    import intc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t set_vec,
    input  logic  clr_en,
    input  word_t clr_data,
    output word_t raw
);
    word_t raw_q;
    word_t keep;
    word_t raw_d;

    always_comb begin
        keep  = clr_en ? (raw_q & clr_data) : raw_q;
        raw_d = (set_vec | keep) & src_field();
    end

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= raw_d;
    end

    assign raw = raw_q;
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc
    import intc_pkg::*;
#(
    parameter int LO = SRC_LO,
    parameter int HI = SRC_HI
) (
    input  word_t pend,
    output pend_t sel
);
    always_comb begin
        sel = '0;
        for (int k = HI; k >= LO; k--) begin
            if (pend[k]) begin
                sel.valid = 1'b1;
                sel.idx   = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/intc_cause_mask.sv
module intc_cause_mask
    import intc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [intc_pkg::NSRC-1:0] src_in,
    input  logic                      reg_sel,
    input  logic                      reg_we,
    input  logic [intc_pkg::DW-1:0]   reg_wdata,
    output logic [intc_pkg::DW-1:0]   reg_rdata,
    output logic                      cpu_irq,
    output logic                      pend_valid,
    output logic [intc_pkg::IDX_W-1:0] pend_idx
);
    logic [NSRC-1:0] rise;
    word_t rise_word;
    word_t cause_raw;
    word_t mask_q;
    word_t pend_word;
    pend_t pend_sel;
    logic  wr_cause;
    logic  wr_mask;

    intc_edge_detect #(.W(NSRC)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (src_in),
        .rise (rise)
    );

    always_comb begin
        rise_word = '0;
        for (int k = 0; k < NSRC; k++) rise_word[k + SRC_LO] = rise[k];
    end

    assign wr_cause = reg_we && (reg_sel_e'(reg_sel) == SEL_CAUSE);
    assign wr_mask  = reg_we && (reg_sel_e'(reg_sel) == SEL_MASK);

    intc_cause_reg u_cause (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (rise_word),
        .clr_en   (wr_cause),
        .clr_data (reg_wdata),
        .raw      (cause_raw)
    );

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (wr_mask) mask_q <= reg_wdata & src_field();
    end

    assign pend_word = cause_raw & mask_q & src_field();

    intc_prio_enc #(.LO(SRC_LO), .HI(SRC_HI)) u_prio (
        .pend (pend_word),
        .sel  (pend_sel)
    );

    assign cpu_irq    = |pend_word;
    assign pend_valid = pend_sel.valid;
    assign pend_idx   = pend_sel.idx;

    always_comb begin
        if (reg_sel_e'(reg_sel) == SEL_MASK) reg_rdata = mask_q;
        else                                 reg_rdata = compose_cause(cause_raw);
    end
endmodule

// File: rtl/intc_chk.sv
module intc_chk
    import intc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_sel,
    input logic             reg_we,
    input word_t            reg_wdata,
    input word_t            reg_rdata,
    input logic             cpu_irq,
    input logic             pend_valid,
    input logic [IDX_W-1:0] pend_idx,
    input word_t            rise_word,
    input word_t            cause_raw,
    input word_t            mask_q
);
    // R2
    edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (|rise_word) |=> ((cause_raw & $past(rise_word)) == $past(rise_word)));

    // R3
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rise_word == '0) |=> ((cause_raw & ~$past(cause_raw)) == '0));

    // R3
    clear_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == 1'b0) |=>
        ((cause_raw & ~$past(reg_wdata) & ~$past(rise_word) & src_field()) == '0));

    // R5
    sum_any_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 1'b0) |-> (reg_rdata[0] == |(reg_rdata & src_field())));

    // R8
    mask_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 1'b1) |-> ((reg_rdata & ~src_field()) == '0));

    // R11
    valid_matches_irq_chk: assert property (@(posedge clk) disable iff (rst)
        pend_valid == cpu_irq);

    // R11
    lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
        pend_valid |-> (cause_raw[pend_idx] && mask_q[pend_idx] &&
        ((cause_raw & mask_q & src_field() & ((word_t'(1) << pend_idx) - word_t'(1))) == '0)));
endmodule

bind intc_cause_mask intc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_sel    (reg_sel),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .cpu_irq    (cpu_irq),
    .pend_valid (pend_valid),
    .pend_idx   (pend_idx),
    .rise_word  (rise_word),
    .cause_raw  (cause_raw),
    .mask_q     (mask_q)
);

// File: tb/test_intc_cause_mask.sv
module test_intc_cause_mask;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 29;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_in = '0;
    logic          reg_sel = 1'b0;
    logic          reg_we = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          cpu_irq;
    logic          pend_valid;
    logic [4:0]    pend_idx;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_raw;
    logic [31:0] exp_mask;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intc_cause_mask i_intc_cause_mask (
        .clk(clk), .rst(rst), .src_in(src_in), .reg_sel(reg_sel),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_irq(cpu_irq), .pend_valid(pend_valid), .pend_idx(pend_idx)
    );

    function automatic logic [31:0] all_src();
        logic [31:0] v = '0;
        for (int i = 1; i <= 29; i++) v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] model_cause(input logic [31:0] raw);
        logic [31:0] r;
        logic a, m, l;
        a = 1'b0; m = 1'b0; l = 1'b0;
        for (int i = 1; i <= 29; i++) begin
            if (raw[i]) begin
                a = 1'b1;
                if (i <= 20 || i >= 26) m = 1'b1;
                if (i <= 25) l = 1'b1;
            end
        end
        r = raw & all_src();
        r[0] = a; r[30] = m; r[31] = l;
        return r;
    endfunction

    function automatic int model_lowest(input logic [31:0] raw, input logic [31:0] msk);
        for (int i = 1; i <= 29; i++) if (raw[i] && msk[i]) return i;
        return 0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(input int pos);
        @(negedge clk);
        src_in[pos - 1] = 1'b1;
        @(negedge clk);
        src_in[pos - 1] = 1'b0;
    endtask

    task automatic check_state(input string tag);
        logic [31:0] v;
        logic [31:0] e;
        int lo;
        rd(1'b0, v);
        e = model_cause(exp_raw);
        chk({tag, " R2 R3 cause word"}, v & all_src(), e & all_src());
        chk({tag, " R5 bit0"}, 32'(v[0]), 32'(e[0]));
        chk({tag, " R6 bit30"}, 32'(v[30]), 32'(e[30]));
        chk({tag, " R7 bit31"}, 32'(v[31]), 32'(e[31]));
        lo = model_lowest(exp_raw, exp_mask);
        chk({tag, " R10 irq"}, 32'(cpu_irq), 32'(lo != 0));
        chk({tag, " R11 valid"}, 32'(pend_valid), 32'(lo != 0));
        if (lo != 0) chk({tag, " R11 index"}, 32'(pend_idx), 32'(lo));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        exp_raw = '0;
        exp_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(1'b0, v); chk("R1 cause after reset", v, 32'h0);
        rd(1'b1, v); chk("R1 mask after reset", v, 32'h0);
        chk("R1 irq after reset", 32'(cpu_irq), 32'h0);
        chk("R1 valid after reset", 32'(pend_valid), 32'h0);

        // single-source sweep: R2, R5-R7, R9, R10, R11, R3
        for (int i = 1; i <= 29; i++) begin
            pulse(i);
            exp_raw[i] = 1'b1;
            check_state("sweep set");
            wr(1'b1, 32'h1 << i);
            exp_mask = 32'h1 << i;
            rd(1'b1, v); chk("R9 mask readback", v, exp_mask);
            check_state("sweep masked");
            wr(1'b0, ~(32'h1 << i));
            exp_raw[i] = 1'b0;
            check_state("sweep cleared R3");
            wr(1'b1, 32'h0);
            exp_mask = '0;
        end

        // R3 R8: writing ones sets nothing; reserved mask positions read 0
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v); chk("R3 R8 cause write ones", v, 32'h0);
        wr(1'b1, 32'hFFFF_FFFF);
        exp_mask = all_src();
        rd(1'b1, v); chk("R8 mask reserved bits", v, all_src());

        // R11 pairwise priority sweep
        for (int i = 1; i <= 29; i++) begin
            for (int j = i + 1; j <= 29; j++) begin
                @(negedge clk);
                src_in[i - 1] = 1'b1; src_in[j - 1] = 1'b1;
                @(negedge clk);
                src_in = '0;
                exp_raw = (32'h1 << i) | (32'h1 << j);
                chk("R11 pair lowest", 32'(pend_idx), 32'(i));
                wr(1'b0, ~(32'h1 << i));
                exp_raw[i] = 1'b0;
                chk("R11 pair next", 32'(pend_idx), 32'(j));
                wr(1'b0, 32'h0);
                exp_raw = '0;
                chk("R10 pair all clear", 32'(cpu_irq), 32'h0);
            end
        end

        // R12: masked-off source still drives summaries
        wr(1'b1, all_src() & ~32'h2);
        exp_mask = all_src() & ~32'h2;
        pulse(1);
        exp_raw[1] = 1'b1;
        check_state("R12 masked low");
        pulse(27);
        exp_raw[27] = 1'b1;
        check_state("R12 R6 high");
        wr(1'b0, 32'h0);
        exp_raw = '0;
        check_state("R12 cleared");

        // R4: event and clearing write in the same cycle
        pulse(3); pulse(7);
        exp_raw = (32'h1 << 3) | (32'h1 << 7);
        check_state("R4 before");
        @(negedge clk);
        src_in[3] = 1'b1;               // position 4
        reg_sel = 1'b0; reg_wdata = 32'h0; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; src_in = '0;
        exp_raw = 32'h1 << 4;
        check_state("R4 new bit wins");
        @(negedge clk);
        src_in[3] = 1'b1;               // position 4 already set
        reg_wdata = 32'h0; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; src_in = '0;
        check_state("R4 set bit kept");
        wr(1'b0, 32'h0);
        exp_raw = '0;

        // R2: held-high source does not re-set after clear
        @(negedge clk);
        src_in[9] = 1'b1;
        @(negedge clk);
        exp_raw[10] = 1'b1;
        check_state("R2 held high set");
        wr(1'b0, 32'h0);
        exp_raw = '0;
        repeat (3) @(negedge clk);
        check_state("R2 held high no reset");
        src_in = '0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule